// File: doc/BRIEF.md
# Descriptor-Chained I2C Master Sequencer

The sequencer runs I2C master transfers described by a small table of transmit and receive descriptors held inside the block. Each descriptor has a 16-bit status word, a 16-bit length and an 8-bit pointer into a 256-byte buffer RAM. The host loads descriptors and buffer bytes through a simple write port, then issues a go command. From that point the sequencer works through the transmit descriptors in order. For each byte-level action it asks a separate I2C engine through a request/acknowledge handshake, and it writes completion and error bits back into the status words.

When a transmit descriptor requests a start condition and its first byte has bit 0 set, that descriptor is a read. The address byte is sent, and every remaining length count becomes a read command. The received bytes go to the buffer named by the current receive descriptor. A no-acknowledge or a collision reported by the engine ends the chain. Every chain finishes with a one-cycle done pulse and a sticky error level.

The controller state machine has these states: IDLE, FETCH, START, XFER, STOP, WBACK and DONE. Its transitions are:
- IDLE→FETCH on go.
- FETCH→DONE when the current descriptor is not ready. FETCH→WBACK when the length is zero. FETCH→START when the start flag is set. Otherwise FETCH→XFER.
- START→XFER on acknowledge. START→WBACK on collision.
- XFER stays in XFER while bytes remain. At the last byte, XFER→STOP if the last flag is set, otherwise XFER→WBACK. XFER→STOP on a no-acknowledge. XFER→WBACK on collision.
- STOP→WBACK on acknowledge.
- WBACK→FETCH normally. WBACK→DONE after an abort.
- DONE→IDLE.

Top module: `i2c_desc_seq`

## Requirements
- R1: After reset, busy, done, err and eng_req are all 0.
- R2: Host map. host_sel 0 selects the transmit table and 1 the receive table, with host_addr = index*4 + field (0 status, 1 length, 2 pointer). host_sel 2 selects a buffer byte. A host_sel 3 write with host_wdata bits 7 and 0 both set starts a chain from transmit and receive index 0. A write with bit 0 clear starts nothing and changes no descriptor.
- R3: Engine commands are coded 0 start, 1 stop, 2 write, 3 read. A descriptor with status bit 0x0400 is preceded by a start. A descriptor with the last flag 0x0800 is followed by a stop.
- R4: A write descriptor sends its length bytes in order, from buffer[pointer] upward.
- R5: A completed transmit descriptor has its ready bit 0x8000 cleared and all other status bits kept.
- R6: When the first byte after a start has bit 0 set, the remaining length-1 bytes are read commands. The received bytes are stored from the receive descriptor's pointer upward, and that descriptor's empty bit 0x8000 is cleared.
- R7: During a read, the final byte is answered with NACK (eng_nack=1) and every earlier byte with ACK.
- R8: A no-acknowledge on a written byte sets 0x0004 and issues a stop. Ready is cleared and later descriptors are left untouched. The chain ends with done and err.
- R9: A collision sets 0x0001 and ends the chain at once, with no stop command.
- R10: A ready descriptor of length 0 gets underflow 0x0002, causes no engine command, and ends the chain with err.
- R11: A receive descriptor holds at most min(length, 128) bytes. Excess bytes are discarded and set overrun 0x0002 in its status, and err is raised.
- R12: The chain continues until a descriptor without ready is reached. The wrap flag 0x2000 returns the index to 0. done is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_we | input | 1 | Host write strobe |
| host_sel | input | 2 | Target select: transmit table, receive table, buffer, control |
| host_addr | input | 8 | Descriptor index/field or buffer address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data for the selected location |
| eng_req | output | 1 | Command request to the engine |
| eng_cmd | output | 2 | Command code |
| eng_wdata | output | 8 | Byte to send |
| eng_nack | output | 1 | Answer this read byte with NACK |
| eng_ack | input | 1 | Command finished |
| eng_rdata | input | 8 | Byte received by a read command |
| eng_nak | input | 1 | Slave did not acknowledge a written byte |
| eng_coll | input | 1 | Collision seen during the command |
| busy | output | 1 | Chain in progress |
| done | output | 1 | One-cycle end-of-chain pulse |
| err | output | 1 | Last chain ended with an error |

## Verification
The hardest case to reach is the 128-byte receive cap. It only shows when one read descriptor clocks in more bytes than the cap while its receive descriptor claims more room than the cap. The bench uses a transmit length of 131 against a receive length of 200 and plants a marker byte just past the cap. The engine model can also inject a no-acknowledge or collision at any chosen command index. This lets abort paths be placed on an address byte or mid-data.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
    localparam int BUF_AW = 8;

    localparam logic [15:0] F_READY = 16'h8000;
    localparam logic [15:0] F_WRAP  = 16'h2000;
    localparam logic [15:0] F_LAST  = 16'h0800;
    localparam logic [15:0] F_START = 16'h0400;
    localparam logic [15:0] E_COLL  = 16'h0001;
    localparam logic [15:0] E_UNDR  = 16'h0002;
    localparam logic [15:0] E_NAK   = 16'h0004;
    localparam logic [15:0] E_OVR   = 16'h0002;

    typedef enum logic [1:0] {ENG_START = 2'd0, ENG_STOP = 2'd1, ENG_WRITE = 2'd2, ENG_READ = 2'd3} eng_cmd_t;
    typedef enum logic [1:0] {SEL_TXD = 2'd0, SEL_RXD = 2'd1, SEL_BUF = 2'd2, SEL_CTL = 2'd3} host_sel_t;

    typedef struct packed {
        logic [15:0]       status;
        logic [15:0]       length;
        logic [BUF_AW-1:0] ptr;
    } desc_t;

    function automatic desc_t put_field(desc_t d, logic [1:0] f, logic [15:0] v);
        desc_t r;
        r = d;
        case (f)
            2'd0:    r.status = v;
            2'd1:    r.length = v;
            2'd2:    r.ptr    = v[BUF_AW-1:0];
            default: ;
        endcase
        return r;
    endfunction

    function automatic logic [15:0] get_field(desc_t d, logic [1:0] f);
        case (f)
            2'd0:    return d.status;
            2'd1:    return d.length;
            2'd2:    return 16'(d.ptr);
            default: return 16'h0;
        endcase
    endfunction
endpackage

// File: rtl/i2c_seq_desc_tbl.sv
module i2c_seq_desc_tbl
    import i2c_seq_pkg::*;
#(
    parameter int N_DESC = 4,
    localparam int IW = $clog2(N_DESC)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_we,
    input  logic [1:0]    host_sel,
    input  logic [7:0]    host_addr,
    input  logic [15:0]   host_wdata,
    output logic [15:0]   host_rdata,
    input  logic [IW-1:0] tx_idx,
    input  logic [IW-1:0] rx_idx,
    output desc_t         tx_q,
    output desc_t         rx_q,
    input  logic          tx_wb_en,
    input  logic [15:0]   tx_wb_status,
    input  logic          rx_wb_en,
    input  logic [15:0]   rx_wb_status
);
    logic [IW-1:0] hidx;
    logic [IW-1:0] sel_idx [2];
    logic          wb_en   [2];
    logic [15:0]   wb_val  [2];
    desc_t         rd_q    [2];
    logic [15:0]   hrd     [2];

    assign hidx       = host_addr[IW+1:2];
    assign sel_idx[0] = tx_idx;
    assign sel_idx[1] = rx_idx;
    assign wb_en[0]   = tx_wb_en;
    assign wb_en[1]   = rx_wb_en;
    assign wb_val[0]  = tx_wb_status;
    assign wb_val[1]  = rx_wb_status;

    for (genvar t = 0; t < 2; t++) begin : g_tbl
        desc_t ent [N_DESC];
        logic  hit;
        assign hit = host_we && (host_sel == 2'(t));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < N_DESC; i++) ent[i] <= '0;
            end else begin
                if (hit) ent[hidx] <= put_field(ent[hidx], host_addr[1:0], host_wdata);
                if (wb_en[t]) ent[sel_idx[t]].status <= wb_val[t];
            end
        end

        assign rd_q[t] = ent[sel_idx[t]];
        assign hrd[t]  = get_field(ent[hidx], host_addr[1:0]);
    end

    assign tx_q       = rd_q[0];
    assign rx_q       = rd_q[1];
    assign host_rdata = (host_sel == SEL_RXD) ? hrd[1] : hrd[0];

    a_r5_wb_clears_ready: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wb_en |-> ((tx_wb_status & F_READY) == 16'h0));
endmodule

// File: rtl/i2c_seq_buf.sv
module i2c_seq_buf #(
    parameter int AW = 8,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [7:0]    host_wdata,
    output logic [7:0]    host_rdata,
    input  logic          seq_we,
    input  logic [AW-1:0] seq_waddr,
    input  logic [7:0]    seq_wdata,
    input  logic [AW-1:0] seq_raddr,
    output logic [7:0]    seq_rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (host_we) mem[host_addr] <= host_wdata;
        if (seq_we)  mem[seq_waddr] <= seq_wdata;
    end

    assign host_rdata = mem[host_addr];
    assign seq_rdata  = mem[seq_raddr];
endmodule

// File: rtl/i2c_seq_ctrl.sv
module i2c_seq_ctrl
    import i2c_seq_pkg::*;
#(
    parameter int N_DESC = 4,
    parameter int MAX_RX = 128,
    localparam int IW = $clog2(N_DESC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  desc_t             tx_q,
    input  desc_t             rx_q,
    output logic [IW-1:0]     tx_idx,
    output logic [IW-1:0]     rx_idx,
    output logic              tx_wb_en,
    output logic [15:0]       tx_wb_status,
    output logic              rx_wb_en,
    output logic [15:0]       rx_wb_status,
    output logic [BUF_AW-1:0] buf_raddr,
    input  logic [7:0]        buf_rdata,
    output logic              buf_we,
    output logic [BUF_AW-1:0] buf_waddr,
    output logic [7:0]        buf_wdata,
    output logic              eng_req,
    output logic [1:0]        eng_cmd,
    output logic [7:0]        eng_wdata,
    output logic              eng_nack,
    input  logic              eng_ack,
    input  logic [7:0]        eng_rdata,
    input  logic              eng_nak,
    input  logic              eng_coll,
    output logic              busy,
    output logic              done,
    output logic              err
);
    typedef enum logic [2:0] {S_IDLE, S_FETCH, S_START, S_XFER, S_STOP, S_WBACK, S_DONE} state_t;

    state_t      state, nxt;
    logic [15:0] cnt, tx_err;
    logic        rd_mode, abort, ovr, err_q;

    logic        fire, last_byte, rx_fits, addr_is_read;
    logic [15:0] rx_pos, rx_cap;

    assign fire         = eng_req && eng_ack;
    assign last_byte    = (cnt == tx_q.length - 16'd1);
    assign rx_pos       = cnt - 16'd1;
    assign rx_cap       = (rx_q.length > 16'(MAX_RX)) ? 16'(MAX_RX) : rx_q.length;
    assign rx_fits      = ((rx_q.status & F_READY) != 16'h0) && (rx_pos < rx_cap);
    assign addr_is_read = ((tx_q.status & F_START) != 16'h0) && buf_rdata[0] && (cnt == 16'd0);

    // next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (go) nxt = S_FETCH;
            S_FETCH: begin
                if ((tx_q.status & F_READY) == 16'h0)      nxt = S_DONE;
                else if (tx_q.length == 16'd0)             nxt = S_WBACK;
                else if ((tx_q.status & F_START) != 16'h0) nxt = S_START;
                else                                       nxt = S_XFER;
            end
            S_START: if (fire) nxt = eng_coll ? S_WBACK : S_XFER;
            S_XFER: if (fire) begin
                if (eng_coll)                 nxt = S_WBACK;
                else if (!rd_mode && eng_nak) nxt = S_STOP;
                else if (last_byte)           nxt = ((tx_q.status & F_LAST) != 16'h0) ? S_STOP : S_WBACK;
            end
            S_STOP:  if (fire) nxt = S_WBACK;
            S_WBACK: nxt = abort ? S_DONE : S_FETCH;
            S_DONE:  nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // descriptor walk and per-descriptor bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_idx  <= '0;
            rx_idx  <= '0;
            cnt     <= '0;
            tx_err  <= '0;
            rd_mode <= 1'b0;
            abort   <= 1'b0;
            ovr     <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: if (go) begin
                    tx_idx <= '0;
                    rx_idx <= '0;
                    err_q  <= 1'b0;
                end
                S_FETCH: begin
                    cnt     <= '0;
                    rd_mode <= 1'b0;
                    ovr     <= 1'b0;
                    tx_err  <= '0;
                    abort   <= 1'b0;
                    if (((tx_q.status & F_READY) != 16'h0) && tx_q.length == 16'd0) begin
                        tx_err <= E_UNDR;
                        abort  <= 1'b1;
                    end
                end
                S_START: if (fire && eng_coll) begin
                    tx_err <= tx_err | E_COLL;
                    abort  <= 1'b1;
                end
                S_XFER: if (fire) begin
                    if (eng_coll) begin
                        tx_err <= tx_err | E_COLL;
                        abort  <= 1'b1;
                    end else if (!rd_mode && eng_nak) begin
                        tx_err <= tx_err | E_NAK;
                        abort  <= 1'b1;
                    end else begin
                        cnt <= cnt + 16'd1;
                        if (addr_is_read)         rd_mode <= 1'b1;
                        if (rd_mode && !rx_fits) ovr     <= 1'b1;
                    end
                end
                S_STOP: if (fire && eng_coll) tx_err <= tx_err | E_COLL;
                S_WBACK: begin
                    if (tx_err != 16'h0 || ovr) err_q <= 1'b1;
                    if (!abort) begin
                        tx_idx <= (((tx_q.status & F_WRAP) != 16'h0) || tx_idx == IW'(N_DESC-1))
                                  ? '0 : tx_idx + 1'b1;
                        if (rd_mode)
                            rx_idx <= (((rx_q.status & F_WRAP) != 16'h0) || rx_idx == IW'(N_DESC-1))
                                      ? '0 : rx_idx + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        eng_req      = 1'b0;
        eng_cmd      = ENG_WRITE;
        eng_wdata    = buf_rdata;
        eng_nack     = 1'b0;
        tx_wb_en     = 1'b0;
        rx_wb_en     = 1'b0;
        buf_we       = 1'b0;
        done         = 1'b0;
        tx_wb_status = (tx_q.status & ~F_READY) | tx_err;
        rx_wb_status = (rx_q.status & ~F_READY) | (ovr ? E_OVR : 16'h0);
        buf_raddr    = tx_q.ptr + cnt[BUF_AW-1:0];
        buf_waddr    = rx_q.ptr + rx_pos[BUF_AW-1:0];
        buf_wdata    = eng_rdata;
        unique case (state)
            S_START: begin
                eng_req = 1'b1;
                eng_cmd = ENG_START;
            end
            S_XFER: begin
                eng_req   = 1'b1;
                eng_cmd   = rd_mode ? ENG_READ : ENG_WRITE;
                eng_wdata = rd_mode ? 8'hFF : buf_rdata;
                eng_nack  = rd_mode && last_byte;
                buf_we    = fire && rd_mode && !eng_coll && rx_fits;
            end
            S_STOP: begin
                eng_req = 1'b1;
                eng_cmd = ENG_STOP;
            end
            S_WBACK: begin
                tx_wb_en = 1'b1;
                rx_wb_en = rd_mode;
            end
            S_DONE:  done = 1'b1;
            default: ;
        endcase
    end

    assign busy = (state != S_IDLE);
    assign err  = err_q;

    a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r8_stop_after_nak: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && eng_cmd == ENG_WRITE && eng_nak && !eng_coll) |=> (eng_req && eng_cmd == ENG_STOP));
    a_r9_no_stop_after_coll: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && eng_coll) |=> !eng_req);
    a_r7_nack_only_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        eng_nack |-> (eng_req && eng_cmd == ENG_READ));
    a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !go) |=> !eng_req);
endmodule

// File: rtl/i2c_desc_seq.sv
module i2c_desc_seq
    import i2c_seq_pkg::*;
#(
    parameter int N_DESC = 4,
    parameter int MAX_RX = 128,
    localparam int IW = $clog2(N_DESC)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_we,
    input  logic [1:0]  host_sel,
    input  logic [7:0]  host_addr,
    input  logic [15:0] host_wdata,
    output logic [15:0] host_rdata,
    output logic        eng_req,
    output logic [1:0]  eng_cmd,
    output logic [7:0]  eng_wdata,
    output logic        eng_nack,
    input  logic        eng_ack,
    input  logic [7:0]  eng_rdata,
    input  logic        eng_nak,
    input  logic        eng_coll,
    output logic        busy,
    output logic        done,
    output logic        err
);
    logic              go;
    logic [IW-1:0]     tx_idx, rx_idx;
    desc_t             tx_q, rx_q;
    logic              tx_wb_en, rx_wb_en;
    logic [15:0]       tx_wb_status, rx_wb_status, desc_hrd;
    logic [BUF_AW-1:0] buf_raddr, buf_waddr;
    logic [7:0]        buf_rdata, buf_wdata, buf_hrd;
    logic              buf_we;

    assign go = host_we && (host_sel == SEL_CTL) && host_wdata[7] && host_wdata[0];

    i2c_seq_desc_tbl #(.N_DESC(N_DESC)) u_tbl (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(desc_hrd),
        .tx_idx(tx_idx), .rx_idx(rx_idx), .tx_q(tx_q), .rx_q(rx_q),
        .tx_wb_en(tx_wb_en), .tx_wb_status(tx_wb_status),
        .rx_wb_en(rx_wb_en), .rx_wb_status(rx_wb_status)
    );

    i2c_seq_buf #(.AW(BUF_AW)) u_buf (
        .clk(clk), .host_we(host_we && host_sel == SEL_BUF), .host_addr(host_addr[BUF_AW-1:0]),
        .host_wdata(host_wdata[7:0]), .host_rdata(buf_hrd),
        .seq_we(buf_we), .seq_waddr(buf_waddr), .seq_wdata(buf_wdata),
        .seq_raddr(buf_raddr), .seq_rdata(buf_rdata)
    );

    i2c_seq_ctrl #(.N_DESC(N_DESC), .MAX_RX(MAX_RX)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .go(go), .tx_q(tx_q), .rx_q(rx_q),
        .tx_idx(tx_idx), .rx_idx(rx_idx),
        .tx_wb_en(tx_wb_en), .tx_wb_status(tx_wb_status),
        .rx_wb_en(rx_wb_en), .rx_wb_status(rx_wb_status),
        .buf_raddr(buf_raddr), .buf_rdata(buf_rdata),
        .buf_we(buf_we), .buf_waddr(buf_waddr), .buf_wdata(buf_wdata),
        .eng_req(eng_req), .eng_cmd(eng_cmd), .eng_wdata(eng_wdata), .eng_nack(eng_nack),
        .eng_ack(eng_ack), .eng_rdata(eng_rdata), .eng_nak(eng_nak), .eng_coll(eng_coll),
        .busy(busy), .done(done), .err(err)
    );

    always_comb begin
        unique case (host_sel)
            SEL_TXD, SEL_RXD: host_rdata = desc_hrd;
            SEL_BUF:          host_rdata = {8'h00, buf_hrd};
            default:          host_rdata = 16'h0;
        endcase
    end
endmodule

// File: tb/i2c_desc_seq_test.sv
module i2c_desc_seq_test;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [1:0]  host_sel = 2'd0;
    logic [7:0]  host_addr = 8'd0;
    logic [15:0] host_wdata = 16'd0;
    logic [15:0] host_rdata;
    logic        eng_req, eng_nack, busy, done, err;
    logic [1:0]  eng_cmd;
    logic [7:0]  eng_wdata;
    logic        eng_ack, eng_nak, eng_coll;
    logic [7:0]  eng_rdata;

    always #(PERIOD/2) clk = ~clk;

    i2c_desc_seq uut (.*);

    int checks = 0, errors = 0;
    logic [1:0] lg_cmd [256];
    logic [7:0] lg_dat [256];
    logic       lg_nk  [256];
    int log_n = 0, rd_n = 0, nak_at = -1, coll_at = -1, done_cnt = 0;

    // engine model: answers each request in the following cycle
    initial begin
        eng_ack = 0; eng_nak = 0; eng_coll = 0; eng_rdata = 0;
        forever begin
            @(negedge clk);
            eng_ack = 0; eng_nak = 0; eng_coll = 0;
            if (rst_n && eng_req && log_n < 256) begin
                lg_cmd[log_n] = eng_cmd;
                lg_dat[log_n] = eng_wdata;
                lg_nk[log_n]  = eng_nack;
                eng_nak  = (log_n == nak_at);
                eng_coll = (log_n == coll_at);
                if (eng_cmd == 2'd3) begin
                    eng_rdata = 8'(8'h40 + rd_n);
                    rd_n++;
                end
                log_n++;
                eng_ack = 1;
            end
        end
    end

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic hw(logic [1:0] sel, logic [7:0] a, logic [15:0] d);
        @(negedge clk);
        host_we = 1; host_sel = sel; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 0;
    endtask

    task automatic hr(logic [1:0] sel, logic [7:0] a, output int v);
        host_sel = sel; host_addr = a;
        #1 v = int'(host_rdata);
    endtask

    task automatic set_d(logic [1:0] sel, int i, logic [15:0] st, logic [15:0] len, logic [7:0] p);
        hw(sel, 8'(i*4), st);
        hw(sel, 8'(i*4+1), len);
        hw(sel, 8'(i*4+2), {8'h0, p});
    endtask

    task automatic clear_all();
        for (int i = 0; i < 4; i++) begin
            set_d(2'd0, i, 16'h0, 16'h0, 8'h0);
            set_d(2'd1, i, 16'h0, 16'h0, 8'h0);
        end
        nak_at = -1; coll_at = -1;
    endtask

    task automatic status_is(string req, logic [1:0] sel, int i, int exp);
        int v;
        hr(sel, 8'(i*4), v);
        check(req, $sformatf("status sel%0d[%0d]", sel, i), v, exp);
    endtask

    task automatic buf_is(string req, int a, int exp);
        int v;
        hr(2'd2, 8'(a), v);
        check(req, $sformatf("buf[%0h]", a), v, exp);
    endtask

    task automatic ent_is(string req, int i, int cmd, int dat);
        check(req, $sformatf("cmd[%0d]", i), int'(lg_cmd[i]), cmd);
        if (cmd == 2) check(req, $sformatf("byte[%0d]", i), int'(lg_dat[i]), dat);
    endtask

    task automatic run_go(logic [15:0] ctl);
        log_n = 0; rd_n = 0; done_cnt = 0;
        hw(2'd3, 8'd0, ctl);
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            if (done) done_cnt++;
            if (!busy) break;
        end
    endtask

    task automatic t_reset();
        check("R1", "busy", int'(busy), 0);
        check("R1", "done", int'(done), 0);
        check("R1", "err", int'(err), 0);
        check("R1", "eng_req", int'(eng_req), 0);
    endtask

    task automatic t_gate();
        clear_all();
        set_d(2'd0, 0, 16'h8C00, 16'd1, 8'h00);
        hw(2'd2, 8'h00, 16'h00A0);
        run_go(16'h0080);
        repeat (5) @(negedge clk);
        check("R2", "cmds without enable", log_n, 0);
        check("R2", "busy without enable", int'(busy), 0);
        status_is("R2", 2'd0, 0, 16'h8C00);
    endtask

    task automatic t_write_chain();
        clear_all();
        hw(2'd2, 8'h00, 16'h00A0); hw(2'd2, 8'h01, 16'h0011); hw(2'd2, 8'h02, 16'h0022);
        hw(2'd2, 8'h08, 16'h0033); hw(2'd2, 8'h09, 16'h0044);
        set_d(2'd0, 0, 16'h8400, 16'd3, 8'h00);
        set_d(2'd0, 1, 16'hA800, 16'd2, 8'h08);
        set_d(2'd0, 2, 16'h8000, 16'd1, 8'h00);
        run_go(16'h0081);
        check("R12", "command count", log_n, 7);
        ent_is("R3", 0, 0, 0);
        ent_is("R4", 1, 2, 8'hA0);
        ent_is("R4", 2, 2, 8'h11);
        ent_is("R4", 3, 2, 8'h22);
        ent_is("R4", 4, 2, 8'h33);
        ent_is("R4", 5, 2, 8'h44);
        ent_is("R3", 6, 1, 0);
        status_is("R5", 2'd0, 0, 16'h0400);
        status_is("R5", 2'd0, 1, 16'h2800);
        status_is("R12", 2'd0, 2, 16'h8000);
        check("R12", "done pulses", done_cnt, 1);
        check("R5", "err", int'(err), 0);
    endtask

    task automatic t_read();
        clear_all();
        hw(2'd2, 8'h00, 16'h00A0); hw(2'd2, 8'h01, 16'h0005);
        hw(2'd2, 8'h10, 16'h00A1);
        set_d(2'd0, 0, 16'h8400, 16'd2, 8'h00);
        set_d(2'd0, 1, 16'hAC00, 16'd4, 8'h10);
        set_d(2'd1, 0, 16'hA000, 16'd3, 8'h40);
        run_go(16'h0081);
        check("R6", "command count", log_n, 9);
        ent_is("R3", 3, 0, 0);
        ent_is("R6", 4, 2, 8'hA1);
        ent_is("R6", 5, 3, 0);
        ent_is("R6", 7, 3, 0);
        check("R7", "ack first read", int'(lg_nk[5]), 0);
        check("R7", "ack middle read", int'(lg_nk[6]), 0);
        check("R7", "nack last read", int'(lg_nk[7]), 1);
        ent_is("R3", 8, 1, 0);
        buf_is("R6", 8'h40, 8'h40);
        buf_is("R6", 8'h42, 8'h42);
        status_is("R6", 2'd1, 0, 16'h2000);
        status_is("R5", 2'd0, 1, 16'h2C00);
        check("R6", "err", int'(err), 0);
    endtask

    task automatic t_nak();
        clear_all();
        hw(2'd2, 8'h00, 16'h00A0);
        set_d(2'd0, 0, 16'h8400, 16'd3, 8'h00);
        set_d(2'd0, 1, 16'h8800, 16'd1, 8'h00);
        nak_at = 1;
        run_go(16'h0081);
        check("R8", "command count", log_n, 3);
        ent_is("R8", 2, 1, 0);
        status_is("R8", 2'd0, 0, 16'h0404);
        status_is("R8", 2'd0, 1, 16'h8800);
        check("R8", "err", int'(err), 1);
        check("R8", "done pulses", done_cnt, 1);
    endtask

    task automatic t_coll();
        clear_all();
        hw(2'd2, 8'h00, 16'h00A0);
        set_d(2'd0, 0, 16'h8C00, 16'd3, 8'h00);
        coll_at = 2;
        run_go(16'h0081);
        check("R9", "command count (no stop)", log_n, 3);
        status_is("R9", 2'd0, 0, 16'h0C01);
        check("R9", "err", int'(err), 1);
    endtask

    task automatic t_underflow();
        clear_all();
        set_d(2'd0, 0, 16'h8800, 16'd0, 8'h00);
        run_go(16'h0081);
        check("R10", "command count", log_n, 0);
        status_is("R10", 2'd0, 0, 16'h0802);
        check("R10", "err", int'(err), 1);
    endtask

    task automatic t_overrun();
        clear_all();
        hw(2'd2, 8'h00, 16'h00A1);
        hw(2'd2, 8'h42, 16'h005A);
        set_d(2'd0, 0, 16'hAC00, 16'd4, 8'h00);
        set_d(2'd1, 0, 16'h8000, 16'd2, 8'h40);
        run_go(16'h0081);
        buf_is("R11", 8'h41, 8'h41);
        buf_is("R11", 8'h42, 8'h5A);
        status_is("R11", 2'd1, 0, 16'h0002);
        check("R11", "err", int'(err), 1);
    endtask

    task automatic t_cap();
        clear_all();
        hw(2'd2, 8'h00, 16'h00A1);
        hw(2'd2, 8'h90, 16'h0077);
        set_d(2'd0, 0, 16'h8C00, 16'd131, 8'h00);
        set_d(2'd1, 0, 16'h8000, 16'd200, 8'h10);
        run_go(16'h0081);
        check("R11", "reads issued", rd_n, 130);
        buf_is("R11", 8'h8F, 8'hBF);
        buf_is("R11", 8'h90, 8'h77);
        status_is("R11", 2'd1, 0, 16'h0002);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(PERIOD * 150000);
        checks++; errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_gate();
        t_write_chain();
        t_nak();
        t_read();
        t_coll();
        t_underflow();
        t_overrun();
        t_cap();
        finish_run();
    end
endmodule